// File: doc/BRIEF.md
# T1 Transmit Channel Word Processor

This block sits in the transmit path of a 24-channel T1 line. It rewrites the outgoing serial stream one 8-bit channel word at a time. A frame has 193 bits: one framing bit, then 24 channel words, each sent MSB first. For each word the block can do three things:
- replace the word with an idle code;
- put a robbed-bit signaling value into the word's last bit during signaling frames;
- force the second-to-last bit to one when the word would otherwise be all zeros.

Two per-channel masks control this. The idle mask selects idle substitution. The transparency mask exempts a channel from both signaling insertion and zero suppression. Idle substitution applies to a transparent channel as well.

A host writes the masks and three control bits through a small write port. The host also supplies a frame sync pulse on the framing bit, and a superframe start flag on the framing bit of frame 1. The output is the input delayed by exactly one channel word (8 clocks), so a complete word can be inspected before its first bit leaves.

A position state machine tracks where the input stream is in the frame. It has three states:
- `POS_HUNT`: out of reset, no sync seen yet.
- `POS_FRAMING`: the current bit is the framing bit, expected from the count.
- `POS_CHANNEL`: the current bit belongs to a channel word.

Its transitions are:
- **sync-align**: any state moves to `POS_CHANNEL` with channel 0, bit 0 after a cycle with `fsync` high.
- **hunt-hold**: `POS_HUNT` stays put while there is no sync.
- **framing-exit**: `POS_FRAMING` moves to `POS_CHANNEL`, channel 0, bit 0.
- **bit-step**: inside `POS_CHANNEL`, the bit and channel counts advance.
- **frame-wrap**: after bit 8 of channel 24, the machine moves to `POS_FRAMING`.

A frame counter advances on each framing bit. It wraps at 12 frames, or at 24 frames in extended mode, and is cleared by `sf_start`.

Top module: `t1tx_chan_proc`

## Requirements
- R1: `tx_out` equals `ser_in` delayed by 8 clocks for framing bits, and for channel words the block leaves unchanged (not idle, not transparent with signaling active, no inserted bit, not all zeros).
- R2: Channel n (1 to 24) is controlled by bit (n-1) mod 8 of the register at address (n-1) div 8. Transparency registers are at addresses 0 to 2 and idle registers at addresses 4 to 6. Channel 1 is bit 0 of address 0 and channel 24 is bit 7 of address 2.
- R3: An idle channel's outgoing word is 0x7F when control bit 1 (address 7) is 0, and 0xFF when it is 1.
- R4: With signaling enabled (control bit 0) in 12-frame mode (control bit 2 = 0), the last bit of every non-transparent word in frames 6 and 12 is replaced by the signaling value. Frame 1 is the frame whose framing bit carries `sf_start`.
- R5: In 24-frame mode (control bit 2 = 1), signaling is inserted in frames 6, 12, 18 and 24 only.
- R6: The signaling value is `sig_in` as sampled on the falling clock edge during bit 8 of the word. A later change within that bit has no effect.
- R7: A transparent, non-idle channel's word passes unchanged, with no signaling and no zero suppression.
- R8: An idle channel receives signaling in signaling frames unless it is also transparent.
- R9: A non-transparent word that would be all zeros after idle substitution and signaling insertion goes out as 0x02.
- R10: With signaling disabled, no word is altered by signaling in any frame.
- R11: After reset `tx_out` is 0 and all masks and control bits are clear.
- R12: Without further syncs the position and frame counts run freely over 193-bit frames. A sync at any position realigns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | High during the framing bit of a frame |
| sf_start | input | 1 | High with `fsync` on frame 1 of a superframe |
| ser_in | input | 1 | Serial transmit data in |
| sig_in | input | 1 | Serial signaling value, sampled on the falling edge |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| tx_out | output | 1 | Processed serial data, 8 clocks behind `ser_in` |

## Verification
The bench tries the main function with the following word patterns:
- Mixed data such as 0xA5 and 0x3C, which separates signaling insertion from plain passage.
- All-zero and single-one words, which expose zero suppression both alone and after signaling has cleared the last bit.
- The 0x7F and 0xFF idle codes, combined with signaling and transparency, which separate code selection from the signaling override.

Target frames 1, 6, 9, 12, 18 and 24 are chosen to tell the 12-frame and 24-frame signaling schedules apart. Channels 1, 8, 9, 16, 17 and 24 probe the mask boundaries.

// File: rtl/t1tx_pkg.sv
package t1tx_pkg;

    localparam int unsigned CH_COUNT  = 24;
    localparam int unsigned WORD_BITS = 8;
    localparam int unsigned ADDR_BITS = 3;

    typedef enum logic [1:0] {
        POS_HUNT    = 2'd0,
        POS_FRAMING = 2'd1,
        POS_CHANNEL = 2'd2
    } pos_state_e;

    // bit2: 24-frame mode, bit1: idle code all ones, bit0: signaling enable
    typedef struct packed {
        logic esf_mode;
        logic idle_all_ones;
        logic sig_en;
    } ctrl_t;

endpackage

// File: rtl/t1tx_cfg_regs.sv
module t1tx_cfg_regs
    import t1tx_pkg::*;
#(
    parameter int unsigned NCH       = CH_COUNT,
    parameter int unsigned W         = WORD_BITS,
    parameter int unsigned AW        = ADDR_BITS,
    parameter int unsigned IDLE_BASE = 4,
    parameter int unsigned CTRL_ADDR = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [NCH-1:0] transp_mask,
    output logic [NCH-1:0] idle_mask,
    output ctrl_t          ctrl
);

    localparam int unsigned NBANK  = NCH / W;
    localparam int unsigned CTRL_W = $bits(ctrl_t);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [W-1:0] tr_q;
        logic [W-1:0] id_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tr_q <= '0;
                id_q <= '0;
            end else if (we) begin
                if (addr == AW'(g))             tr_q <= wdata;
                if (addr == AW'(IDLE_BASE + g)) id_q <= wdata;
            end
        end

        assign transp_mask[g*W +: W] = tr_q;
        assign idle_mask[g*W +: W]   = id_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (we && addr == AW'(CTRL_ADDR)) begin
            ctrl <= wdata[CTRL_W-1:0];
        end
    end

    // R2
    first_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == '0) |=> transp_mask[W-1:0] == $past(wdata));

endmodule

// File: rtl/t1tx_pos_fsm.sv
module t1tx_pos_fsm
    import t1tx_pkg::*;
#(
    parameter int unsigned NCH        = CH_COUNT,
    parameter int unsigned W          = WORD_BITS,
    parameter int unsigned SF_FRAMES  = 12,
    parameter int unsigned ESF_FRAMES = 24,
    parameter int unsigned SIG_PERIOD = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fsync,
    input  logic                     sf_start,
    input  logic                     esf_mode,
    output logic [$clog2(NCH)-1:0]   ch_idx,
    output logic                     word_end,
    output logic                     sig_frame
);

    localparam int unsigned CH_W     = $clog2(NCH);
    localparam int unsigned BIT_W    = $clog2(W);
    localparam int unsigned FR_W     = $clog2(ESF_FRAMES);
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NCH - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

    pos_state_e        state, state_n;
    logic [CH_W-1:0]   ch_n;
    logic [BIT_W-1:0]  bit_idx, bit_n;
    logic [FR_W-1:0]   frame_idx;
    logic [FR_W-1:0]   frame_last;
    logic              framing_slot;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= POS_HUNT;
            ch_idx  <= '0;
            bit_idx <= '0;
        end else begin
            state   <= state_n;
            ch_idx  <= ch_n;
            bit_idx <= bit_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        ch_n    = ch_idx;
        bit_n   = bit_idx;
        if (fsync) begin
            state_n = POS_CHANNEL;
            ch_n    = '0;
            bit_n   = '0;
        end else begin
            unique case (state)
                POS_HUNT: begin
                    state_n = POS_HUNT;
                end
                POS_FRAMING: begin
                    state_n = POS_CHANNEL;
                    ch_n    = '0;
                    bit_n   = '0;
                end
                POS_CHANNEL: begin
                    if (bit_idx == LAST_BIT) begin
                        bit_n = '0;
                        if (ch_idx == LAST_CH) begin
                            state_n = POS_FRAMING;
                            ch_n    = '0;
                        end else begin
                            ch_n = ch_idx + 1'b1;
                        end
                    end else begin
                        bit_n = bit_idx + 1'b1;
                    end
                end
                default: begin
                    state_n = POS_HUNT;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        framing_slot = fsync || (state == POS_FRAMING);
        word_end     = !fsync && (state == POS_CHANNEL) && (bit_idx == LAST_BIT);
        sig_frame    = (int'(frame_idx) % SIG_PERIOD) == (SIG_PERIOD - 1);
        frame_last   = esf_mode ? FR_W'(ESF_FRAMES - 1) : FR_W'(SF_FRAMES - 1);
    end

    // frame counter, advanced on each framing bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_idx <= '0;
        end else if (framing_slot) begin
            if (fsync && sf_start)          frame_idx <= '0;
            else if (frame_idx >= frame_last) frame_idx <= '0;
            else                            frame_idx <= frame_idx + 1'b1;
        end
    end

    // R12
    sync_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (state == POS_CHANNEL) && (ch_idx == '0) && (bit_idx == '0));

    // R12
    framing_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == POS_FRAMING) |=> (state == POS_CHANNEL) && (bit_idx == '0));

    // R5
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_start && fsync) |=> frame_idx == '0);

endmodule

// File: rtl/t1tx_word_proc.sv
module t1tx_word_proc #(
    parameter int unsigned W        = 8,
    parameter logic [W-1:0] IDLE_LO = 'h7F,
    parameter logic [W-1:0] IDLE_HI = 'hFF,
    parameter int unsigned ZS_BIT   = 1
) (
    input  logic [W-1:0] raw_word,
    input  logic         transp,
    input  logic         idle,
    input  logic         idle_all_ones,
    input  logic         sig_en,
    input  logic         sig_frame,
    input  logic         sig_bit,
    output logic [W-1:0] word_out
);

    localparam logic [W-1:0] ZS_MASK = W'(1) << ZS_BIT;

    logic [W-1:0] after_idle;
    logic [W-1:0] after_sig;
    logic         insert_sig;
    logic         suppress;

    always_comb begin
        after_idle = idle ? (idle_all_ones ? IDLE_HI : IDLE_LO) : raw_word;
        insert_sig = sig_en && sig_frame && !transp;
        after_sig  = after_idle;
        if (insert_sig) after_sig[0] = sig_bit;
        suppress   = !transp && (after_sig == '0);
        word_out   = suppress ? (after_sig | ZS_MASK) : after_sig;
    end

endmodule

// File: rtl/t1tx_chan_proc.sv
module t1tx_chan_proc
    import t1tx_pkg::*;
#(
    parameter int unsigned NCH = CH_COUNT,
    parameter int unsigned W   = WORD_BITS,
    parameter int unsigned AW  = ADDR_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    input  logic          sf_start,
    input  logic          ser_in,
    input  logic          sig_in,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [W-1:0]  cfg_wdata,
    output logic          tx_out
);

    localparam int unsigned CH_W  = $clog2(NCH);
    localparam int unsigned CNT_W = $clog2(W + 1);

    logic [NCH-1:0]  transp_mask;
    logic [NCH-1:0]  idle_mask;
    ctrl_t           ctrl;
    logic [CH_W-1:0] ch_idx;
    logic            word_end;
    logic            sig_frame;

    logic [W-2:0]    in_sr;
    logic [W-1:0]    dly;
    logic [W-1:0]    raw_word;
    logic [W-1:0]    proc_word;
    logic [W-1:0]    word_sr;
    logic [CNT_W-1:0] out_left;
    logic            sig_cap;
    logic            cur_tr;
    logic            cur_idle;
    logic [3:0]      warm_cnt;

    t1tx_cfg_regs #(.NCH(NCH), .W(W), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .transp_mask (transp_mask),
        .idle_mask   (idle_mask),
        .ctrl        (ctrl)
    );

    t1tx_pos_fsm #(.NCH(NCH), .W(W)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .sf_start  (sf_start),
        .esf_mode  (ctrl.esf_mode),
        .ch_idx    (ch_idx),
        .word_end  (word_end),
        .sig_frame (sig_frame)
    );

    assign cur_tr   = transp_mask[ch_idx];
    assign cur_idle = idle_mask[ch_idx];
    assign raw_word = {in_sr, ser_in};

    t1tx_word_proc #(.W(W)) u_word (
        .raw_word      (raw_word),
        .transp        (cur_tr),
        .idle          (cur_idle),
        .idle_all_ones (ctrl.idle_all_ones),
        .sig_en        (ctrl.sig_en),
        .sig_frame     (sig_frame),
        .sig_bit       (sig_cap),
        .word_out      (proc_word)
    );

    // signaling value taken mid-bit on the falling edge of the last word bit
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)                     sig_cap <= 1'b0;
        else if (word_end && sig_frame) sig_cap <= sig_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sr    <= '0;
            dly      <= '0;
            word_sr  <= '0;
            out_left <= '0;
            warm_cnt <= '0;
        end else begin
            in_sr <= {in_sr[W-3:0], ser_in};
            dly   <= {dly[W-2:0], ser_in};
            if (warm_cnt != 4'd15) warm_cnt <= warm_cnt + 1'b1;
            if (word_end) begin
                word_sr  <= proc_word;
                out_left <= CNT_W'(W);
            end else if (out_left != '0) begin
                word_sr  <= {word_sr[W-2:0], 1'b0};
                out_left <= out_left - 1'b1;
            end
        end
    end

    assign tx_out = (out_left != '0) ? word_sr[W-1] : dly[W-1];

    // R1
    gap_bit_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt >= 4'd9 && out_left == '0) |-> tx_out == $past(ser_in, 8));

    // R9
    no_zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && !cur_tr) |=> word_sr != '0);

    // R7
    transp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && cur_tr && !cur_idle) |=> word_sr == $past(raw_word));

    // R3
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && cur_idle && !(ctrl.sig_en && sig_frame && !cur_tr))
        |=> word_sr == ($past(ctrl.idle_all_ones) ? {W{1'b1}} : {1'b0, {(W-1){1'b1}}}));

    // R10
    sig_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && !ctrl.sig_en && !cur_idle && raw_word != '0) |=> word_sr == $past(raw_word));

endmodule

// File: tb/tb_t1tx_chan_proc.sv
`timescale 1ns/100ps
module tb_t1tx_chan_proc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       sf_start = 1'b0;
    logic       ser_in = 1'b0;
    logic       sig_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       tx_out;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;
    int  gcnt = 0;
    int  tgt_g = -100;
    int  f_g = -100;
    logic [7:0] cap_word;
    logic       cap_f;

    always #2 clk = ~clk;   // 250 MHz

    t1tx_chan_proc dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .sf_start(sf_start),
        .ser_in(ser_in), .sig_in(sig_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .tx_out(tx_out)
    );

    typedef struct packed {
        logic [4:0] ch;
        logic [7:0] data;
        logic       sig;
        logic [4:0] frame;
        logic       tr;
        logic       idle;
        logic       sig_en;
        logic       idle_ff;
        logic       esf;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{5'd1,  8'hA5, 1'b1, 5'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 4'd1},  // R1 not a signaling frame
        '{5'd1,  8'hA5, 1'b0, 5'd6,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA4, 4'd4},  // R4 frame 6
        '{5'd24, 8'h3C, 1'b1, 5'd12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3D, 4'd2},  // R2 channel 24, frame 12
        '{5'd10, 8'h3C, 1'b1, 5'd6,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 4'd10}, // R10 signaling off
        '{5'd9,  8'h00, 1'b0, 5'd2,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 4'd9},  // R9 zero word
        '{5'd9,  8'h00, 1'b0, 5'd2,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd7},  // R7 zero word transparent
        '{5'd17, 8'h81, 1'b0, 5'd6,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h81, 4'd7},  // R7 no signaling
        '{5'd5,  8'h12, 1'b0, 5'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h7F, 4'd3},  // R3 idle 7F
        '{5'd5,  8'h12, 1'b0, 5'd3,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 4'd3},  // R3 idle FF
        '{5'd8,  8'h12, 1'b0, 5'd6,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h7E, 4'd8},  // R8 idle with signaling
        '{5'd8,  8'h12, 1'b0, 5'd6,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 4'd8},  // R8 idle transparent
        '{5'd16, 8'h01, 1'b0, 5'd6,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h02, 4'd9},  // R9 zero after signaling
        '{5'd20, 8'hF0, 1'b1, 5'd18, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hF1, 4'd5},  // R5 frame 18
        '{5'd3,  8'h0F, 1'b0, 5'd24, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h0E, 4'd5},  // R5 frame 24
        '{5'd3,  8'h0F, 1'b0, 5'd9,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h0F, 4'd5},  // R5 frame 9
        '{5'd2,  8'hFF, 1'b0, 5'd12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFE, 4'd5},  // R5 frame 12
        '{5'd12, 8'hAA, 1'b1, 5'd18, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hAB, 4'd4}   // R4 wrap, frame 6 again
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_cfg(input int ch, input logic tr, input logic idle, input logic [2:0] ctl);
        for (int r = 0; r < 3; r++) begin
            logic [7:0] m;
            m = ((ch - 1) / 8 == r) ? (8'd1 << ((ch - 1) % 8)) : 8'd0;
            wr(3'(r), tr ? m : 8'd0);
            wr(3'(4 + r), idle ? m : 8'd0);
        end
        wr(3'd7, {5'd0, ctl});
    endtask

    task automatic send_bit(input logic d, input logic fs, input logic s, input logic late);
        int g;
        @(posedge clk); #1;
        ser_in = d; fsync = fs; sf_start = fs; sig_in = s;
        #1.5;
        if (late) sig_in = ~s;
        #0.5;
        g = gcnt;
        gcnt++;
        if (g >= tgt_g + 8 && g <= tgt_g + 15) cap_word = {cap_word[6:0], tx_out};
        if (g == f_g + 8) cap_f = tx_out;
    endtask

    // fsync and sf_start only on frame 1; later frames rely on free running
    task automatic run_case(input int ch, input logic [7:0] data, input logic sig,
                            input int frame, input logic late);
        tgt_g = -100; f_g = -100; cap_word = 'x; cap_f = 1'bx;
        for (int f = 1; f <= frame + 1; f++) begin
            for (int p = 0; p < ((f == frame + 1) ? 24 : 193); p++) begin
                if (p == 0) begin
                    if (f == frame) f_g = gcnt;
                    send_bit(frame[0] & (f == frame), f == 1, 1'b0, 1'b0);
                end else begin
                    int chn;
                    int b;
                    chn = (p - 1) / 8 + 1;
                    b   = (p - 1) % 8;
                    if (f == frame && chn == ch) begin
                        if (b == 0) tgt_g = gcnt;
                        send_bit(data[7 - b], 1'b0, (b == 7) ? sig : 1'b0, (b == 7) && late);
                    end else begin
                        send_bit(1'((p * 5) >> 1), 1'b0, 1'b0, 1'b0);
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R11 output low after reset
        check("R11", {7'd0, tx_out}, 8'h00);
        // R11 masks cleared: zero word is suppressed, data word is not idled
        run_case(4, 8'h00, 1'b0, 1, 1'b0);
        check("R11", cap_word, 8'h02);
        run_case(4, 8'h5A, 1'b0, 1, 1'b0);
        check("R11", cap_word, 8'h5A);

        for (int i = 0; i < NV; i++) begin
            set_cfg(VECS[i].ch, VECS[i].tr, VECS[i].idle,
                    {VECS[i].esf, VECS[i].idle_ff, VECS[i].sig_en});
            run_case(VECS[i].ch, VECS[i].data, VECS[i].sig, VECS[i].frame, 1'b0);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), cap_word, VECS[i].exp);
            // R1 framing bit delayed by one word
            check("R1 framing", {7'd0, cap_f}, {7'd0, VECS[i].frame[0]});
        end

        // R6 sig_in flipped after the falling edge: the sampled value wins
        set_cfg(1, 1'b0, 1'b0, 3'b001);
        run_case(1, 8'h80, 1'b1, 6, 1'b1);
        check("R6", cap_word, 8'h81);

        // R12 sync arrives at an odd position after 77 free-running bits
        for (int k = 0; k < 77; k++) send_bit(1'b1, 1'b0, 1'b0, 1'b0);
        run_case(24, 8'h00, 1'b1, 12, 1'b0);
        check("R12", cap_word, 8'h01);
        check("R12 framing", {7'd0, cap_f}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule